// File: doc/BRIEF.md
# Byte ALU with AES Field Operations

This block is the arithmetic-logic unit of a small 8-bit RISC core. Each cycle it takes two byte operands, a 4-bit operation code and the incoming carry flag. It returns a byte result, the next carry flag and a zero flag. The unit is purely combinational, so every operation settles within one machine cycle.

Besides the usual add, subtract, bitwise and shift operations, it offers three single-instruction AES primitives. These are multiplication of two bytes in GF(2^8), the forward byte substitution of operand A, and the inverse byte substitution of operand A. Software on the core builds full cipher rounds and key schedules out of these instructions. The register file, fetch and decode all sit outside this unit.

Both substitutions share one inversion circuit in the field. The forward path inverts and then applies the affine map. The inverse path applies the inverse affine map and then inverts.

Top module: `aes_byte_alu`

## Requirements
- R1: Code 0 (add) gives result = (A + B) mod 256, with carry out equal to bit 8 of the 9-bit sum.
- R2: Code 1 (subtract) gives result = (A - B) mod 256, with carry out set to 1 exactly when A < B (borrow).
- R3: Codes 2, 3 and 4 give A AND B, A OR B and A XOR B. Code 5 gives NOT A, and B has no effect on it. For codes 2 to 5 the carry out equals carry in.
- R4: Code 6 shifts A left by one with a zero fill, and carry out takes A bit 7. Code 7 shifts A right by one with a zero fill, and carry out takes A bit 0.
- R5: Code 8 gives the product of A and B in GF(2^8), reduced by x^8+x^4+x^3+x+1 (0x11B). For example, 0x57 times 0x83 is 0xC1.
- R6: Code 9 gives the AES forward substitution of A, which is field inversion (0 maps to 0) followed by the affine map with constant 0x63. S(0x00)=0x63, S(0x53)=0xED, and B has no effect.
- R7: Code 10 gives the AES inverse substitution of A, so InvS(S(x)) = x for all 256 bytes. B has no effect.
- R8: Codes 8, 9 and 10 drive carry out to 0 whatever the carry in.
- R9: Codes 11 to 15 give result 0x00, and carry out equals carry in.
- R10: The zero flag is 1 exactly when the result is 0x00, for every code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation code |
| opa | input | 8 | Operand A |
| opb | input | 8 | Operand B |
| cin | input | 1 | Current carry flag |
| res | output | 8 | Result byte |
| cout | output | 1 | Next carry flag |
| zf | output | 1 | Result-is-zero flag |

## Verification
The field inversion of zero must yield zero. A design that got this wrong would put a wrong value at S(0x00) and break the round trip at 0x63. The bench compares every substitution and every inverse substitution with a table it builds by brute-force search for inverses, and it drives every operand pair through multiply, add and subtract. This exposes a wrong reduction polynomial, a swapped borrow sense, or a sum carry taken from the wrong bit. Shifts are checked for the bit that leaves into the carry. Logic and unused codes are checked with both carry-in values, which catches a carry that is cleared where it should pass through, or one that leaks through the AES codes.

// File: rtl/aes_byte_alu.sv
module aes_byte_alu (
  input  logic [3:0] op,
  input  logic [7:0] opa,
  input  logic [7:0] opb,
  input  logic       cin,
  output logic [7:0] res,
  output logic       cout,
  output logic       zf
);
  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_SUB  = 4'd1;
  localparam logic [3:0] OP_AND  = 4'd2;
  localparam logic [3:0] OP_OR   = 4'd3;
  localparam logic [3:0] OP_XOR  = 4'd4;
  localparam logic [3:0] OP_NOT  = 4'd5;
  localparam logic [3:0] OP_SHL  = 4'd6;
  localparam logic [3:0] OP_SHR  = 4'd7;
  localparam logic [3:0] OP_GMUL = 4'd8;
  localparam logic [3:0] OP_SUBS = 4'd9;
  localparam logic [3:0] OP_ISUB = 4'd10;
  localparam logic [7:0] RED     = 8'h1B;
  localparam logic [7:0] FWD_C   = 8'h63;
  localparam logic [7:0] INV_C   = 8'h05;

  function automatic logic [7:0] xtime(input logic [7:0] v);
    return {v[6:0], 1'b0} ^ (v[7] ? RED : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] x, input logic [7:0] y);
    logic [7:0] acc, p;
    acc = 8'h00;
    p   = x;
    for (int i = 0; i < 8; i++) begin
      if (y[i]) acc = acc ^ p;
      p = xtime(p);
    end
    return acc;
  endfunction

  // x^254 = x^-1 in GF(2^8), and 0 maps to 0
  function automatic logic [7:0] ginv(input logic [7:0] x);
    logic [7:0] sq, acc;
    sq  = x;
    acc = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq  = gmul(sq, sq);
      acc = gmul(acc, sq);
    end
    return acc;
  endfunction

  function automatic logic [7:0] rotl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  logic [8:0] sum, dif;
  logic [7:0] inv_in, inv_out, fwd_out, bwd_out;

  assign sum     = {1'b0, opa} + {1'b0, opb};
  assign dif     = {1'b0, opa} - {1'b0, opb};
  assign inv_in  = (op == OP_ISUB)
                 ? (rotl(opa, 1) ^ rotl(opa, 3) ^ rotl(opa, 6) ^ INV_C)
                 : opa;
  assign inv_out = ginv(inv_in);
  assign fwd_out = inv_out ^ rotl(inv_out, 1) ^ rotl(inv_out, 2)
                 ^ rotl(inv_out, 3) ^ rotl(inv_out, 4) ^ FWD_C;
  assign bwd_out = inv_out;

  always_comb begin
    res  = 8'h00;
    cout = cin;
    unique case (op)
      OP_ADD:  begin res = sum[7:0]; cout = sum[8]; end
      OP_SUB:  begin res = dif[7:0]; cout = dif[8]; end
      OP_AND:  res = opa & opb;
      OP_OR:   res = opa | opb;
      OP_XOR:  res = opa ^ opb;
      OP_NOT:  res = ~opa;
      OP_SHL:  begin res = {opa[6:0], 1'b0}; cout = opa[7]; end
      OP_SHR:  begin res = {1'b0, opa[7:1]}; cout = opa[0]; end
      OP_GMUL: begin res = gmul(opa, opb); cout = 1'b0; end
      OP_SUBS: begin res = fwd_out; cout = 1'b0; end
      OP_ISUB: begin res = bwd_out; cout = 1'b0; end
      default: res = 8'h00;
    endcase
  end

  assign zf = (res == 8'h00);
endmodule

module aes_byte_alu_chk (
  input logic [3:0] op,
  input logic [7:0] opa,
  input logic [7:0] opb,
  input logic       cin,
  input logic [7:0] res,
  input logic       cout,
  input logic       zf
);
  always_comb begin
    assert_add_wrap_R1: assert (!(op == 4'd0) || (cout == (res < opa)));
    assert_sub_borrow_R2: assert (!(op == 4'd1) || (cout == (opa < opb)));
    assert_not_inverts_R3: assert (!(op == 4'd5) || ((res ^ opa) == 8'hFF));
    assert_and_subset_R3: assert (!(op == 4'd2) || ((res & ~opa) == 8'h00));
    assert_shl_carry_R4: assert (!(op == 4'd6) || (cout == opa[7] && !res[0]));
    assert_shr_carry_R4: assert (!(op == 4'd7) || (cout == opa[0] && !res[7]));
    assert_aes_carry_clear_R8: assert (!(op >= 4'd8 && op <= 4'd10) || !cout);
    assert_unused_zero_R9: assert (!(op >= 4'd11) || (res == 8'h00 && cout == cin));
    assert_zero_flag_R10: assert (zf == (res == 8'h00));
  end
endmodule

bind aes_byte_alu aes_byte_alu_chk u_chk (.*);

// File: tb/test_aes_byte_alu.sv
module test_aes_byte_alu;
  logic       clk = 1'b0;
  logic [3:0] op;
  logic [7:0] opa, opb;
  logic       cin;
  logic [7:0] res;
  logic       cout, zf;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [7:0] sbox_t [256];
  logic [7:0] isbox_t [256];

  always #2.5 clk = ~clk;

  aes_byte_alu i_aes_byte_alu (
    .op(op), .opa(opa), .opb(opb), .cin(cin),
    .res(res), .cout(cout), .zf(zf)
  );

  function automatic logic [7:0] rmul(input logic [7:0] x, input logic [7:0] y);
    logic [14:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (y[i]) p = p ^ (15'(x) << i);
    for (int i = 14; i >= 8; i--) if (p[i]) p = p ^ (15'h11B << (i - 8));
    return p[7:0];
  endfunction

  function automatic logic [7:0] rinv(input logic [7:0] x);
    logic [7:0] r;
    r = 8'h00;
    for (int k = 1; k < 256; k++) if (rmul(x, 8'(k)) == 8'h01) r = 8'(k);
    return r;
  endfunction

  function automatic logic [7:0] rl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  task automatic drive(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b, input logic c);
    op = o; opa = a; opb = b; cin = c;
    #1;
  endtask

  task automatic chk8(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%02h b=%02h: got %02h expected %02h", tag, op, opa, opb, got, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%02h b=%02h cin=%0b: got %0b expected %0b", tag, op, opa, opb, cin, got, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic [7:0] er, input logic ec);
    chk8(tag, res, er);
    chk1(tag, cout, ec);
    chk1("R10 zero flag", zf, er == 8'h00);
  endtask

  initial begin
    for (int x = 0; x < 256; x++) begin
      logic [7:0] v;
      v = rinv(8'(x));
      sbox_t[x] = v ^ rl(v, 1) ^ rl(v, 2) ^ rl(v, 3) ^ rl(v, 4) ^ 8'h63;
    end
    for (int x = 0; x < 256; x++) isbox_t[sbox_t[x]] = 8'(x);

    drive(4'd0, 8'h00, 8'h00, 1'b0);
    chk_all("R1 idle add", 8'h00, 1'b0);

    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++) begin
        logic [8:0] s;
        s = 9'(a) + 9'(b);
        drive(4'd0, 8'(a), 8'(b), b[0]);
        chk_all("R1 add", s[7:0], s[8]);
      end

    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++) begin
        drive(4'd1, 8'(a), 8'(b), a[0]);
        chk_all("R2 sub", 8'(a - b), a < b);
      end

    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b += 17) begin
        logic c;
        c = a[1] ^ b[0];
        drive(4'd2, 8'(a), 8'(b), c); chk_all("R3 and", 8'(a & b), c);
        drive(4'd3, 8'(a), 8'(b), c); chk_all("R3 or", 8'(a | b), c);
        drive(4'd4, 8'(a), 8'(b), c); chk_all("R3 xor", 8'(a ^ b), c);
        drive(4'd5, 8'(a), 8'(b), c); chk_all("R3 not", ~8'(a), c);
      end

    for (int a = 0; a < 256; a++)
      for (int c = 0; c < 2; c++) begin
        drive(4'd6, 8'(a), 8'(255 - a), c[0]);
        chk_all("R4 shl", 8'(a << 1), a[7]);
        drive(4'd7, 8'(a), 8'(255 - a), c[0]);
        chk_all("R4 shr", 8'(a >> 1), a[0]);
      end

    drive(4'd8, 8'h57, 8'h83, 1'b1);
    chk_all("R5 known product", 8'hC1, 1'b0);
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++) begin
        drive(4'd8, 8'(a), 8'(b), a[2]);
        chk_all("R5 R8 gf multiply", rmul(8'(a), 8'(b)), 1'b0);
      end

    drive(4'd9, 8'h00, 8'hFF, 1'b1);
    chk_all("R6 S(00)", 8'h63, 1'b0);
    drive(4'd9, 8'h53, 8'h00, 1'b0);
    chk_all("R6 S(53)", 8'hED, 1'b0);
    for (int x = 0; x < 256; x++) begin
      logic [7:0] s;
      drive(4'd9, 8'(x), 8'(x) ^ 8'hA5, 1'b1);
      chk_all("R6 R8 sbox", sbox_t[x], 1'b0);
      s = res;
      drive(4'd10, s, 8'(x), 1'b1);
      chk_all("R7 round trip", 8'(x), 1'b0);
      drive(4'd10, 8'(x), 8'(255 - x), x[0]);
      chk_all("R7 R8 inverse sbox", isbox_t[x], 1'b0);
    end

    for (int o = 11; o < 16; o++)
      for (int a = 0; a < 256; a += 15)
        for (int c = 0; c < 2; c++) begin
          drive(4'(o), 8'(a), 8'(a) ^ 8'h3C, c[0]);
          chk_all("R9 unused code", 8'h00, c[0]);
        end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule